// File: doc/BRIEF.md
# Factorial Accelerator Register Unit

This block is a small memory-mapped register slave. It sits on a simple 32-bit read/write register port that carries a byte offset and an access-size code. It holds four registers: a read-only identification word, a liveness register that hands back the inverse of whatever was last written, an operand register that feeds an iterative factorial engine, and a status register.

Writing the operand register while the engine is idle starts the computation. The engine does one 32-bit multiply per clock, stepping the operand down towards one. When it finishes, the truncated product overwrites the operand register. The status register shows a busy flag and holds an interrupt-enable flag. When interrupts are enabled, the unit sends a one-cycle raise request for interrupt bit 0x01 to an external interrupt collector each time a computation completes.

Reads return registered data one cycle after the request. Each offset below 0x80 accepts only full-word accesses. Any other access size gets all ones on a read and is discarded on a write.

Top module: `fact_reg_unit`

## Requirements
- R1: A read of offset 0x00 returns 0x010000ED: major version 0x01 in bits 31:24, minor version 0x00 in bits 23:16, and 0x00ED in the low half. Writes to offset 0x00 change nothing.
- R2: A 4-byte write to offset 0x04 stores the bitwise inverse of the write data. A read of 0x04 returns that stored inverse.
- R3: A 4-byte write to offset 0x08 while the engine is idle loads the operand and starts a computation. Busy (status bit 0, mask 0x01 at offset 0x20) reads as 1 from the next cycle on.
- R4: A write to offset 0x08 while busy is set is ignored, and the running computation and its result are unaffected.
- R5: For an operand n, the product n·(n-1)·…·1 truncated to 32 bits replaces the operand register, and busy clears, max(n,1) clock edges after the edge that accepted the start. Operands 0 and 1 yield 1.
- R6: Status bit 7 (mask 0x80) is read/write interrupt enable. If it is set when a computation finishes, `irq_raise` is high for exactly one cycle, in the same cycle busy first reads 0. Otherwise `irq_raise` stays low.
- R7: Status bit 0 is read-only: writing 0x01 or 0x00 to offset 0x20 never changes busy.
- R8: `bus_size` encodes 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. For offsets below 0x80 only code 2 is honoured: a read of any other size returns 0xFFFFFFFF, and a write of any other size changes no register. At 0x80 and above, codes 2 and 3 are accepted.
- R9: Read data and `bus_rvalid` appear on the cycle after a read request. A read of an unmapped offset with an accepted size returns 0.
- R10: After reset the liveness, operand and status registers read 0, and `irq_raise` and `bus_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset into the register window |
| bus_size | input | 2 | Access size code (0=1B, 1=2B, 2=4B, 3=8B) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq_raise | output | 1 | One-cycle request to raise interrupt bit 0x01 |

## Verification
Read data is due one edge after the read request, so the bench drives on the falling edge and samples on the next falling edge. Busy therefore reads as 1 from the read that follows a start, for operands of 2 and above. Counting from the edge that accepts the operand write, the bench steps edge by edge and expects `irq_raise` low until edge max(n,1) and high only in the cycle after that edge. The operand read-back and the status read are placed after that point. Random liveness traffic, rejected-size writes, unmapped reads and factorial runs with random operands and enable bits are compared against a bench model of the register values and a bench factorial function.

// File: rtl/fru_pkg.sv
package fru_pkg;
    localparam int DW = 32;

    localparam logic [DW-1:0] ID_WORD = 32'h0100_00ED;

    localparam int OFF_ID   = 'h00;
    localparam int OFF_LIVE = 'h04;
    localparam int OFF_OPND = 'h08;
    localparam int OFF_STAT = 'h20;
    localparam int WIDE_OK_FROM = 'h80;

    localparam int STAT_BUSY  = 0;
    localparam int STAT_IRQEN = 7;

    localparam logic [1:0] SZ_WORD  = 2'd2;
    localparam logic [1:0] SZ_DWORD = 2'd3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ID,
        SEL_LIVE,
        SEL_OPND,
        SEL_STAT
    } sel_e;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] cnt;
        logic          busy;
    } eng_t;

    typedef struct packed {
        logic [DW-1:0] live;
        logic [DW-1:0] opnd;
        logic          irq_en;
        logic          irq_req;
        logic [DW-1:0] rdata;
        logic          rvalid;
    } regs_t;
endpackage

// File: rtl/fru_decode.sv
module fru_decode
    import fru_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output sel_e              sel,
    output logic              size_ok
);
    localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFF_ID);
    localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(OFF_LIVE);
    localparam logic [ADDR_W-1:0] A_OPND = ADDR_W'(OFF_OPND);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_WIDE = ADDR_W'(WIDE_OK_FROM);

    logic wide_zone;

    always_comb begin
        wide_zone = (addr >= A_WIDE);
        if (wide_zone) begin
            size_ok = (size == SZ_WORD) || (size == SZ_DWORD);
        end else begin
            size_ok = (size == SZ_WORD);
        end

        unique case (addr)
            A_ID:    sel = SEL_ID;
            A_LIVE:  sel = SEL_LIVE;
            A_OPND:  sel = SEL_OPND;
            A_STAT:  sel = SEL_STAT;
            default: sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/fru_mul_engine.sv
module fru_mul_engine
    import fru_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] operand,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] result
);
    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        done  = 1'b0;
        if (!eng_q.busy) begin
            if (start) begin
                eng_d.acc  = DW'(1);
                eng_d.cnt  = operand;
                eng_d.busy = 1'b1;
            end
        end else if (eng_q.cnt <= DW'(1)) begin
            done       = 1'b1;
            eng_d.busy = 1'b0;
        end else begin
            eng_d.acc = eng_q.acc * eng_q.cnt;
            eng_d.cnt = eng_q.cnt - DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy   = eng_q.busy;
    assign result = eng_q.acc;

    // R3: an accepted start makes the engine busy on the next cycle
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R5: completion drops busy on the next cycle
    p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R5: completion is only reported while a run is active
    p_done_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

// File: rtl/fact_reg_unit.sv
module fact_reg_unit
    import fru_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              irq_raise
);
    sel_e          sel;
    logic          size_ok;
    logic          wr_ok;
    logic          rd_req;
    logic          eng_start;
    logic          eng_busy;
    logic          eng_done;
    logic [DW-1:0] eng_result;
    logic [DW-1:0] stat_word;
    regs_t         r_d, r_q;

    fru_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .size    (bus_size),
        .sel     (sel),
        .size_ok (size_ok)
    );

    fru_mul_engine u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .operand (bus_wdata),
        .busy    (eng_busy),
        .done    (eng_done),
        .result  (eng_result)
    );

    always_comb begin
        wr_ok     = bus_req && bus_we && size_ok;
        rd_req    = bus_req && !bus_we;
        eng_start = wr_ok && (sel == SEL_OPND) && !eng_busy;

        stat_word             = '0;
        stat_word[STAT_BUSY]  = eng_busy;
        stat_word[STAT_IRQEN] = r_q.irq_en;

        r_d         = r_q;
        r_d.irq_req = 1'b0;
        r_d.rvalid  = rd_req;

        if (wr_ok) begin
            case (sel)
                SEL_LIVE: r_d.live   = ~bus_wdata;
                SEL_STAT: r_d.irq_en = bus_wdata[STAT_IRQEN];
                default:  ;
            endcase
        end

        if (eng_start) begin
            r_d.opnd = bus_wdata;
        end
        if (eng_done) begin
            r_d.opnd    = eng_result;
            r_d.irq_req = r_q.irq_en;
        end

        if (rd_req) begin
            if (!size_ok) begin
                r_d.rdata = '1;
            end else begin
                case (sel)
                    SEL_ID:   r_d.rdata = ID_WORD;
                    SEL_LIVE: r_d.rdata = r_q.live;
                    SEL_OPND: r_d.rdata = r_q.opnd;
                    SEL_STAT: r_d.rdata = stat_word;
                    default:  r_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata  = r_q.rdata;
    assign bus_rvalid = r_q.rvalid;
    assign irq_raise  = r_q.irq_req;

    // R4: the operand register holds still during a run until it completes
    p_opnd_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && !eng_done) |=> $stable(r_q.opnd));

    // R6: the interrupt request is a single-cycle pulse
    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_raise |=> !irq_raise);

    // R6: a request only follows a completion with interrupts enabled
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_raise) |-> $past(eng_done && r_q.irq_en));

    // R8: a rejected-size read answers with all ones
    p_bad_size_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !size_ok) |=> (bus_rdata == '1));

    // R9: read data is flagged valid exactly one cycle after a read request
    p_rvalid_timing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);
endmodule

// File: tb/sim_fact_reg_unit.sv
`timescale 1ns/100ps
module sim_fact_reg_unit;
    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [1:0]        bus_size = 2'd2;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic              irq_raise;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [31:0] live_m = '0;

    always #2.5 clk = ~clk;

    fact_reg_unit #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_raise(irq_raise)
    );

    function automatic logic [31:0] fact32(input logic [31:0] n);
        logic [31:0] p = 32'd1;
        for (int k = 2; k <= int'(n); k++) p = p * 32'(k);
        return p;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data, input logic [1:0] sz);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(addr);
        bus_size = sz; bus_wdata = data;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int addr, input logic [1:0] sz, output logic [31:0] data);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(addr); bus_size = sz;
        @(negedge clk);
        data = bus_rdata;
        chk("R9 rvalid after read", 32'(bus_rvalid), 32'd1);
        bus_req = 1'b0;
    endtask

    // Writes operand n (status already set), then checks the irq timing
    // edge by edge and the result read-back.
    task automatic run_fact(input logic [31:0] n, input bit en);
        logic [31:0] v;
        int lat = (n <= 1) ? 1 : int'(n);
        wr('h08, n, 2'd2);
        for (int k = 1; k <= lat; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk((k == lat) ? "R6 irq at completion" : "R6 irq quiet while busy",
                32'(irq_raise), 32'((k == lat) && en));
        end
        rd('h08, 2'd2, v);
        chk("R5 result", v, fact32(n));
        chk("R6 irq single cycle", 32'(irq_raise), 32'd0);
        rd('h20, 2'd2, v);
        chk("R5 busy cleared", v, {24'd0, en, 7'd0});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired (R5 engine hang)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20250);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        chk("R10 irq low", 32'(irq_raise), 32'd0);
        chk("R10 rvalid low", 32'(bus_rvalid), 32'd0);
        rd('h04, 2'd2, v); chk("R10 live reset", v, 32'd0);
        rd('h08, 2'd2, v); chk("R10 operand reset", v, 32'd0);
        rd('h20, 2'd2, v); chk("R10 status reset", v, 32'd0);

        // R1 identification and its write protection
        rd('h00, 2'd2, v); chk("R1 id", v, 32'h0100_00ED);
        wr('h00, 32'h1234_5678, 2'd2);
        rd('h00, 2'd2, v); chk("R1 id after write", v, 32'h0100_00ED);

        // R2 liveness inverse
        wr('h04, 32'hA5A5_0F0F, 2'd2); live_m = 32'h5A5A_F0F0;
        rd('h04, 2'd2, v); chk("R2 live inverse", v, live_m);

        // R8 size rules
        wr('h04, 32'h0000_0000, 2'd3);
        rd('h04, 2'd2, v); chk("R8 8-byte write dropped", v, live_m);
        wr('h04, 32'hFFFF_0000, 2'd0);
        rd('h04, 2'd2, v); chk("R8 1-byte write dropped", v, live_m);
        rd('h00, 2'd1, v); chk("R8 2-byte read ones", v, 32'hFFFF_FFFF);
        rd('h08, 2'd3, v); chk("R8 8-byte read ones", v, 32'hFFFF_FFFF);
        rd('h80, 2'd3, v); chk("R8 R9 wide zone 8-byte read", v, 32'd0);
        rd('h80, 2'd0, v); chk("R8 wide zone 1-byte read ones", v, 32'hFFFF_FFFF);

        // R9 unmapped reads
        rd('h40, 2'd2, v); chk("R9 unmapped 0x40", v, 32'd0);
        rd('h0C, 2'd2, v); chk("R9 unmapped 0x0C", v, 32'd0);

        // R7 busy bit read-only while idle
        wr('h20, 32'h0000_0001, 2'd2);
        rd('h20, 2'd2, v); chk("R7 busy not writable", v, 32'd0);

        // R3 start and busy visible; R7 clearing busy by write has no effect
        wr('h08, 32'd10, 2'd2);
        rd('h20, 2'd2, v); chk("R3 busy after start", v, 32'h0000_0001);
        wr('h20, 32'h0000_0000, 2'd2);
        rd('h20, 2'd2, v); chk("R7 busy survives write", v, 32'h0000_0001);
        // R4 write during busy ignored
        wr('h08, 32'd3, 2'd2);
        repeat (12) @(posedge clk);
        rd('h08, 2'd2, v); chk("R4 R5 locked operand result", v, fact32(32'd10));
        rd('h20, 2'd2, v); chk("R5 idle after run", v, 32'd0);

        // R4 operand write right after start, with interrupt timing
        wr('h20, 32'h0000_0080, 2'd2);
        wr('h08, 32'd6, 2'd2);
        wr('h08, 32'd2, 2'd2);
        repeat (8) @(posedge clk);
        rd('h08, 2'd2, v); chk("R4 second write ignored", v, 32'd720);

        // R5 R6 directed corners: 0, 1, 2, 13 (wraps), 34 (zero)
        run_fact(32'd0, 1'b1);
        run_fact(32'd1, 1'b1);
        run_fact(32'd2, 1'b1);
        run_fact(32'd13, 1'b1);
        run_fact(32'd34, 1'b1);
        wr('h20, 32'h0000_0000, 2'd2);
        run_fact(32'd5, 1'b0);

        // random mix
        for (int i = 0; i < 40; i++) begin
            int op = int'($urandom_range(0, 3));
            case (op)
                0: begin
                    logic [31:0] d = $urandom();
                    wr('h04, d, 2'd2); live_m = ~d;
                    rd('h04, 2'd2, v); chk("R2 random live", v, live_m);
                end
                1: begin
                    bit en = 1'($urandom_range(0, 1));
                    logic [31:0] n = 32'($urandom_range(0, 20));
                    wr('h20, {24'd0, en, 6'd0, 1'($urandom_range(0, 1))}, 2'd2);
                    run_fact(n, en);
                end
                2: begin
                    logic [1:0] sz = 2'($urandom_range(0, 2));
                    if (sz == 2'd2) sz = 2'd3;
                    wr('h04, $urandom(), sz);
                    rd('h04, 2'd2, v); chk("R8 random bad-size write", v, live_m);
                end
                default: begin
                    int a = 'h0C + 4 * int'($urandom_range(0, 4));
                    rd(a, 2'd2, v); chk("R9 random unmapped", v, 32'd0);
                end
            endcase
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule